// File: doc/BRIEF.md
# Sideband Mailbox Register Bridge

This block lets a host reach registers inside many on-chip units over a sideband fabric. The host sees three 32-bit registers on a simple configuration port. One is a data word, one is an upper-offset extension and one is a command word. Writing the command word is the trigger. That write sends exactly one request to the fabric. The request carries the opcode, the target port, the byte enables and the full 32-bit register offset. For write opcodes the request also carries the data word. The fabric side has a valid/ready request channel and a single-cycle response channel that returns read data or an error.

A small state machine runs each transaction. It has three states. In `S_IDLE` no transaction is open. `S_ISSUE` presents the request until the fabric accepts it. `S_WAIT` waits for the response. The state machine has four named transitions:
- **launch** (`S_IDLE`→`S_ISSUE`): a command write to any port other than the fenced one.
- **refuse** (`S_IDLE`→`S_IDLE`): a command write to the fenced port. The bridge raises a sticky status flag and sends no request.
- **accept** (`S_ISSUE`→`S_WAIT`): `req_ready` is high.
- **complete** (`S_WAIT`→`S_IDLE`): `rsp_valid` is high.

The host reads status from the low nibble of the command word. The bits mean busy, fabric error, overrun and refused. A read-modify-write is done by the host as two transactions. Both use the same port and offset. The read opcode has bit 0 clear and the write opcode has bit 0 set.

Top module: `sbmb_bridge`

## Requirements
- R1: The command word is at address 0xD0, the data word at 0xD4 and the extension at 0xD8. The data word reads back as written. The extension keeps bits [31:8] and reads 0 in bits [7:0]. Reading the command word returns the last accepted bits [31:4] with status in [3:0]: bit 0 busy, bit 1 fabric error, bit 2 overrun, bit 3 refused. Any other address reads 0, and writes to it change nothing.
- R2: An accepted command write starts a request. The request's `req_valid` is high in the next cycle. Its fields are: opcode = command bits [31:24], port = [23:16], byte enables = [7:4], offset = {extension[31:8], command[15:8]}, and write data = the data word.
- R3: While `req_valid` is high and `req_ready` is low, `req_valid` and every request field stay unchanged.
- R4: Every command write accepted while idle clears the extension to zero, so an upper offset is never used twice.
- R5: A command write aimed at port 0x06 sends no request and sets the sticky refused bit. Busy stays 0.
- R6: Busy reads 1 from the cycle after the command write. It stays 1 until the cycle after the response.
- R7: A good response to a read opcode (opcode bit 0 = 0) loads the data word. A host read of the data word while busy is held off with `cfg_ready` low until the transaction ends.
- R8: An error response sets the sticky fabric-error bit and leaves the data word unchanged.
- R9: Command and data writes that arrive while busy are dropped. They set the sticky overrun bit and send no request.
- R10: After reset all three registers and all status bits read 0, and `req_valid` is low.
- R11: The opcode reaches the fabric unchanged, including bit 0. A read (0x00, 0x06, 0x10) followed by a write (0x01, 0x07, 0x11) to the same port and offset therefore carries out a masked update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Host access request |
| cfg_write | input | 1 | 1 = write, 0 = read |
| cfg_addr | input | 8 | Host register address |
| cfg_wdata | input | 32 | Host write data |
| cfg_ready | output | 1 | Access completes this cycle |
| cfg_rdata | output | 32 | Host read data, valid when ready |
| req_valid | output | 1 | Fabric request valid |
| req_ready | input | 1 | Fabric accepts request |
| req_opcode | output | 8 | Request opcode |
| req_port | output | 8 | Target unit port |
| req_offset | output | 32 | Full register offset |
| req_be | output | 4 | Byte enables |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Response strobe, one cycle |
| rsp_err | input | 1 | Response carries an error |
| rsp_rdata | input | 32 | Response read data |

## Verification
The assertions assume the fabric never sends a response while a request is still waiting for acceptance. They also assume `rsp_valid` is a one-cycle strobe that arrives only after the accept edge. The bench's fabric model keeps to this by answering a set number of cycles after each handshake. The host model holds `cfg_valid` and its fields steady until `cfg_ready` and changes them only between edges. Overrun writes are driven while a long-latency write is known to be outstanding. Refused and dropped commands are seen as missing requests on the fabric monitor.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;
    localparam int DATA_W   = 32;
    localparam int OP_W     = 8;
    localparam int PORT_W   = 8;
    localparam int LO_W     = 8;
    localparam int BE_W     = 4;
    localparam int OP_LSB   = 24;
    localparam int PORT_LSB = 16;
    localparam int LO_LSB   = 8;
    localparam int BE_LSB   = 4;
    localparam int ST_W     = BE_LSB;
    localparam int HI_W     = DATA_W - LO_W;

    localparam int ST_BUSY = 0;
    localparam int ST_FERR = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_REF  = 3;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ISSUE = 2'd1,
        S_WAIT  = 2'd2
    } fsm_state_e;

    typedef struct packed {
        logic [OP_W-1:0]   opcode;
        logic [PORT_W-1:0] port;
        logic [DATA_W-1:0] offset;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } sb_req_t;
endpackage

// File: rtl/sbmb_host_regs.sv
module sbmb_host_regs
    import sbmb_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR  = 8'hD0,
    parameter logic [ADDR_W-1:0] DATA_ADDR = 8'hD4,
    parameter logic [ADDR_W-1:0] EXT_ADDR  = 8'hD8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              cfg_ready,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              busy,
    input  logic              refused,
    input  logic              done,
    input  logic              done_err,
    input  logic [DATA_W-1:0] done_rdata,
    output logic              launch,
    output sb_req_t           launch_req
);
    logic [DATA_W-1:ST_W] cmd_q;
    logic [HI_W-1:0]      ext_q;
    logic [DATA_W-1:0]    data_q;
    logic                 ferr_q, ovr_q, refd_q;

    logic hit_cmd, hit_data, hit_ext, wr_fire, cmd_wr, data_wr, busy_drop;

    assign hit_cmd   = (cfg_addr == CMD_ADDR);
    assign hit_data  = (cfg_addr == DATA_ADDR);
    assign hit_ext   = (cfg_addr == EXT_ADDR);
    assign cfg_ready = !(cfg_valid && !cfg_write && hit_data && busy);
    assign wr_fire   = cfg_valid && cfg_write;
    assign cmd_wr    = wr_fire && hit_cmd && !busy;
    assign data_wr   = wr_fire && hit_data && !busy;
    assign busy_drop = wr_fire && (hit_cmd || hit_data) && busy;

    assign launch = cmd_wr;
    always_comb begin
        launch_req.opcode = cfg_wdata[OP_LSB +: OP_W];
        launch_req.port   = cfg_wdata[PORT_LSB +: PORT_W];
        launch_req.offset = {ext_q, cfg_wdata[LO_LSB +: LO_W]};
        launch_req.be     = cfg_wdata[BE_LSB +: BE_W];
        launch_req.wdata  = data_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            ext_q  <= '0;
            data_q <= '0;
            ferr_q <= 1'b0;
            ovr_q  <= 1'b0;
            refd_q <= 1'b0;
        end else begin
            if (cmd_wr) begin
                cmd_q <= cfg_wdata[DATA_W-1:ST_W];
                ext_q <= '0;
            end else if (wr_fire && hit_ext) begin
                ext_q <= cfg_wdata[DATA_W-1:LO_W];
            end
            if (data_wr) begin
                data_q <= cfg_wdata;
            end else if (done && !done_err && !cmd_q[OP_LSB]) begin
                data_q <= done_rdata;
            end
            if (done && done_err) ferr_q <= 1'b1;
            if (busy_drop)        ovr_q  <= 1'b1;
            if (refused)          refd_q <= 1'b1;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        if (hit_cmd) begin
            cfg_rdata = {cmd_q, refd_q, ovr_q, ferr_q, busy};
        end else if (hit_data) begin
            cfg_rdata = data_q;
        end else if (hit_ext) begin
            cfg_rdata = {ext_q, {LO_W{1'b0}}};
        end
    end

    // R4: an accepted command leaves no upper offset behind
    a_r4_ext_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> (ext_q == '0));
    // R8: a failed response does not touch the data word
    a_r8_err_keeps_data: assert property (@(posedge clk) disable iff (!rst_n)
        (done && done_err) |=> $stable(data_q));
    // R9: overrun is sticky
    a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_q |=> ovr_q);
    // R9: a data write while busy is dropped
    a_r9_busy_data_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && hit_data && busy && !done) |=> $stable(data_q));
endmodule

// File: rtl/sbmb_req_fsm.sv
module sbmb_req_fsm
    import sbmb_pkg::*;
#(
    parameter logic [PORT_W-1:0] BLOCKED_PORT = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  sb_req_t           launch_req,
    output logic              busy,
    output logic              refused,
    output logic              done,
    output logic              done_err,
    output logic [DATA_W-1:0] done_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output sb_req_t           req,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [DATA_W-1:0] rsp_rdata
);
    fsm_state_e state_q, state_d;
    sb_req_t    req_q;
    logic       fenced;

    assign fenced = (launch_req.port == BLOCKED_PORT);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (launch && !fenced) state_d = S_ISSUE;
            S_ISSUE: if (req_ready)         state_d = S_WAIT;
            S_WAIT:  if (rsp_valid)         state_d = S_IDLE;
            default:                        state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && launch && !fenced) req_q <= launch_req;
        end
    end

    always_comb begin
        busy       = 1'b0;
        refused    = 1'b0;
        done       = 1'b0;
        req_valid  = 1'b0;
        unique case (state_q)
            S_IDLE:  refused   = launch && fenced;
            S_ISSUE: begin busy = 1'b1; req_valid = 1'b1; end
            S_WAIT:  begin busy = 1'b1; done = rsp_valid; end
            default: ;
        endcase
        done_err   = rsp_err;
        done_rdata = rsp_rdata;
        req        = req_q;
    end

    // R3: request held while stalled
    a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req)));
    // R5: the fenced port never reaches the fabric
    a_r5_no_fenced_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (req.port != BLOCKED_PORT));
    // R6: busy persists until a response completes
    a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
    // R2: a launch from idle presents a request next cycle
    a_r2_launch_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && launch && !fenced) |=> req_valid);
endmodule

// File: rtl/sbmb_bridge.sv
module sbmb_bridge
    import sbmb_pkg::*;
#(
    parameter int                ADDR_W       = 8,
    parameter logic [ADDR_W-1:0] CMD_ADDR     = 8'hD0,
    parameter logic [ADDR_W-1:0] DATA_ADDR    = 8'hD4,
    parameter logic [ADDR_W-1:0] EXT_ADDR     = 8'hD8,
    parameter logic [7:0]        BLOCKED_PORT = 8'h06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic              cfg_write,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic              cfg_ready,
    output logic [31:0]       cfg_rdata,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [7:0]        req_opcode,
    output logic [7:0]        req_port,
    output logic [31:0]       req_offset,
    output logic [3:0]        req_be,
    output logic [31:0]       req_wdata,
    input  logic              rsp_valid,
    input  logic              rsp_err,
    input  logic [31:0]       rsp_rdata
);
    logic              busy, refused, done, done_err, launch;
    logic [DATA_W-1:0] done_rdata;
    sb_req_t           launch_req, req;

    sbmb_host_regs #(
        .ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR),
        .DATA_ADDR(DATA_ADDR), .EXT_ADDR(EXT_ADDR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_rdata(cfg_rdata),
        .busy(busy), .refused(refused), .done(done), .done_err(done_err),
        .done_rdata(done_rdata), .launch(launch), .launch_req(launch_req)
    );

    sbmb_req_fsm #(.BLOCKED_PORT(BLOCKED_PORT)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .launch(launch), .launch_req(launch_req),
        .busy(busy), .refused(refused), .done(done), .done_err(done_err),
        .done_rdata(done_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req(req),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    assign req_opcode = req.opcode;
    assign req_port   = req.port;
    assign req_offset = req.offset;
    assign req_be     = req.be;
    assign req_wdata  = req.wdata;
endmodule

// File: tb/sbmb_bridge_bench.sv
module sbmb_bridge_bench;
    localparam logic [7:0] A_CMD = 8'hD0, A_DATA = 8'hD4, A_EXT = 8'hD8;

    typedef struct packed {
        logic [7:0]  op;
        logic [7:0]  port;
        logic [31:0] ofs;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [7:0]  stall;
        logic [7:0]  lat;
        logic        err;
        logic [31:0] rd;
    } exp_t;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        cfg_valid = 0, cfg_write = 0;
    logic [7:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic        cfg_ready;
    logic [31:0] cfg_rdata;
    logic        req_valid, req_ready = 0;
    logic [7:0]  req_opcode, req_port;
    logic [31:0] req_offset, req_wdata;
    logic [3:0]  req_be;
    logic        rsp_valid = 0, rsp_err = 0;
    logic [31:0] rsp_rdata = 0;

    int   n_checks = 0, n_err = 0;
    bit   finished = 0;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    sbmb_bridge u_sbmb_bridge (
        .clk(clk), .rst_n(rst_n),
        .cfg_valid(cfg_valid), .cfg_write(cfg_write), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_ready(cfg_ready), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_opcode(req_opcode),
        .req_port(req_port), .req_offset(req_offset), .req_be(req_be),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_valid = 1; cfg_write = 1; cfg_addr = a; cfg_wdata = d;
        #1;
        while (!cfg_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        cfg_valid = 0; cfg_write = 0;
    endtask

    task automatic host_read(input logic [7:0] a, output logic [31:0] d,
                             output int waits);
        waits = 0;
        @(negedge clk);
        cfg_valid = 1; cfg_write = 0; cfg_addr = a;
        #1;
        while (!cfg_ready) begin waits++; @(negedge clk); #1; end
        d = cfg_rdata;
        @(posedge clk); #1;
        cfg_valid = 0;
    endtask

    // driver: push the expected fabric item, then trigger with the command word
    task automatic issue(input logic [31:0] cmd, input logic [31:0] ofs,
                         input logic [31:0] wd, input int stall, input int lat,
                         input bit err, input logic [31:0] rd);
        exp_t e;
        e.op = cmd[31:24]; e.port = cmd[23:16]; e.be = cmd[7:4];
        e.ofs = ofs; e.wd = wd; e.stall = 8'(stall); e.lat = 8'(lat);
        e.err = err; e.rd = rd;
        exp_q.push_back(e);
        host_write(A_CMD, cmd);
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        int w;
        for (int i = 0; i < 100; i++) begin
            host_read(A_CMD, v, w);
            if (!v[0]) return;
        end
        check(0, "R6 busy never cleared", v, 32'h0);
    endtask

    // monitor / fabric model: pops expected items and compares on each request
    initial begin
        exp_t e;
        logic [83:0] first;
        forever begin
            @(negedge clk);
            req_ready = 0;
            if (req_valid) begin
                if (exp_q.size() == 0) begin
                    check(0, "R5/R9 unexpected request port", {24'h0, req_port}, 32'h0);
                    e = '0;
                end else begin
                    e = exp_q.pop_front();
                end
                first = {req_opcode, req_port, req_offset, req_be, req_wdata};
                for (int s = 0; s < int'(e.stall); s++) @(negedge clk);
                if (e.stall != 0)
                    check(req_valid && first == {req_opcode, req_port, req_offset, req_be, req_wdata},
                          "R3 request held while stalled", req_offset, first[35:4]);
                check(req_opcode == e.op, "R2/R11 opcode", {24'h0, req_opcode}, {24'h0, e.op});
                check(req_port == e.port, "R2 port", {24'h0, req_port}, {24'h0, e.port});
                check(req_offset == e.ofs, "R2/R4 offset", req_offset, e.ofs);
                check(req_be == e.be, "R2 byte enables", {28'h0, req_be}, {28'h0, e.be});
                if (e.op[0])
                    check(req_wdata == e.wd, "R2/R11 write data", req_wdata, e.wd);
                req_ready = 1;
                @(negedge clk);
                req_ready = 0;
                for (int l = 0; l < int'(e.lat); l++) @(negedge clk);
                rsp_valid = 1; rsp_err = e.err; rsp_rdata = e.rd;
                @(negedge clk);
                rsp_valid = 0; rsp_err = 0; rsp_rdata = 32'h0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_err++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, old_v, new_v;
        int w;
        repeat (5) @(negedge clk);
        rst_n = 1;

        // R10 reset state
        check(!req_valid, "R10 req_valid after reset", {31'h0, req_valid}, 32'h0);
        host_read(A_CMD, v, w);  check(v == 32'h0, "R10 command/status", v, 32'h0);
        host_read(A_DATA, v, w); check(v == 32'h0, "R10 data", v, 32'h0);
        host_read(A_EXT, v, w);  check(v == 32'h0, "R10 extension", v, 32'h0);

        // R1 register map
        host_write(A_DATA, 32'hCAFE_F00D);
        host_read(A_DATA, v, w); check(v == 32'hCAFE_F00D, "R1 data readback", v, 32'hCAFE_F00D);
        host_write(A_EXT, 32'h1234_5678);
        host_read(A_EXT, v, w);  check(v == 32'h1234_5600, "R1 extension readback", v, 32'h1234_5600);
        host_write(8'hDC, 32'hFFFF_FFFF);
        host_read(8'hDC, v, w);  check(v == 32'h0, "R1 unmapped read", v, 32'h0);
        host_read(A_DATA, v, w); check(v == 32'hCAFE_F00D, "R1 unmapped write no effect", v, 32'hCAFE_F00D);

        // R2/R6/R4 write with preloaded extension
        issue(32'h1103_40F0, 32'h1234_5640, 32'hCAFE_F00D, 0, 4, 0, 32'h0);
        host_read(A_CMD, v, w);  check(v == 32'h1103_40F1, "R6 busy after command / R1 cmd bits", v, 32'h1103_40F1);
        host_read(A_EXT, v, w);  check(v == 32'h0, "R4 extension cleared", v, 32'h0);
        wait_idle();
        host_read(A_CMD, v, w);  check(v[0] == 1'b0, "R6 busy cleared after response", v, 32'h1103_40F0);

        // R7 read with stalled fabric, stalled host data read
        host_write(A_EXT, 32'h0000_0100);
        issue(32'h1002_88F0, 32'h0000_0188, 32'h0, 3, 2, 0, 32'h1357_9BDF);
        host_read(A_DATA, v, w);
        check(v == 32'h1357_9BDF, "R7 read data returned", v, 32'h1357_9BDF);
        check(w > 0, "R7 data read stalled while busy", w, 32'h1);

        // R4 stale upper offset not reused
        issue(32'h1002_20F0, 32'h0000_0020, 32'h0, 1, 1, 0, 32'hDEAD_0001);
        host_read(A_DATA, v, w); check(v == 32'hDEAD_0001, "R7 second read data", v, 32'hDEAD_0001);

        // R8 error response
        issue(32'h0604_10F0, 32'h0000_0010, 32'h0, 0, 3, 1, 32'hFFFF_FFFF);
        wait_idle();
        host_read(A_DATA, v, w); check(v == 32'hDEAD_0001, "R8 data unchanged on error", v, 32'hDEAD_0001);
        host_read(A_CMD, v, w);  check(v[3:0] == 4'h2, "R8 fabric error flag", {28'h0, v[3:0]}, 32'h2);

        // R5 fenced port
        host_write(A_CMD, 32'h0006_00F0);
        repeat (6) @(negedge clk);
        host_read(A_CMD, v, w);  check(v[3:0] == 4'hA, "R5 refused, not busy", {28'h0, v[3:0]}, 32'hA);

        // R9 overrun while a write is outstanding
        host_write(A_DATA, 32'h0BAD_0BAD);
        issue(32'h0743_08F0, 32'h0000_0008, 32'h0BAD_0BAD, 0, 10, 0, 32'h5555_5555);
        host_write(A_DATA, 32'h1111_1111);
        host_write(A_CMD, 32'h0101_20F0);
        wait_idle();
        repeat (4) @(negedge clk);
        host_read(A_DATA, v, w); check(v == 32'h0BAD_0BAD, "R9 busy data write dropped", v, 32'h0BAD_0BAD);
        host_read(A_CMD, v, w);  check(v == 32'h0743_08FE, "R9 overrun flag, command kept", v, 32'h0743_08FE);

        // R11 read-modify-write through paired opcodes
        issue(32'h00A3_5CF0, 32'h0000_005C, 32'h0, 1, 2, 0, 32'hA5A5_0F0F);
        host_read(A_DATA, old_v, w);
        check(old_v == 32'hA5A5_0F0F, "R11 read phase data", old_v, 32'hA5A5_0F0F);
        new_v = (old_v & ~32'h0000_FF00) | (32'h0000_3C00 & 32'h0000_FF00);
        host_write(A_DATA, new_v);
        issue(32'h01A3_5CF0, 32'h0000_005C, 32'hA5A5_3C0F, 0, 1, 0, 32'h0);
        wait_idle();
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2 all expected requests seen", exp_q.size(), 32'h0);
        host_read(A_CMD, v, w);  check(v[3:0] == 4'hE, "R5/R8/R9 sticky flags", {28'h0, v[3:0]}, 32'hE);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule